// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of general-purpose lines for one chip region. It supports up to 64 lines, and `NUM_LINES` sets how many exist. Software reaches the block through a plain synchronous register port. For each line, software can choose between driving and listening, set the driven level, and read back the input level. Before the block uses an incoming level, that level passes through two flip-flops.

Each line also has its own interrupt controls. Every line watches for a single edge direction, chosen by a sense bit. A detected edge sets a sticky flag, which software clears by writing a one to it. Two outputs summarise the flags: one for interrupts and one for wake-up. Each flag reaches an output only when the matching per-line mask bit allows it.

Registers are 32-bit words. Lines 0 to 31 are in the lower word of each pair and lines 32 to 63 are in the upper word. Address bit 6 picks the line window or the interrupt window. Address bit 2 picks the lower or upper word. Address bits 4:3 pick the register slot. Address bit 5 must be zero for an access to hit a register. Address bits 1:0 are ignored.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, `pad_oe`, `pad_out`, `irq` and `wake` are 0, and every register reads 0.
- R2: Address decode works as follows.
  - Bit 6 = 0 selects the line window. Its slots are: 0 = direction, 2 = input level (read-only), 3 = drive value.
  - Bit 6 = 1 selects the interrupt window. Its slots are: 0 = interrupt mask, 1 = edge sense, 2 = flag, 3 = wake mask.
  - Bit 2 selects the upper word. Line n sits at word n/32, bit n%32.
  - Slot 1 of the line window, and any address with bit 5 set, reads 0 and ignores writes.
  - Read data reflects the current address in the same cycle.
- R3: A direction bit of 1 makes a line an output and 0 makes it an input. `pad_oe` and `pad_out` show a written value from the clock edge that accepts the write.
- R4: The input-level register returns `pad_in` delayed by two flip-flops. A level present at clock edge k can be read after edge k+1.
- R5: A sense bit of 0 detects rising edges and 1 detects falling edges. A pad change sampled at edge k sets the flag at edge k+2. A change in the other direction sets nothing.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. Flags never clear by themselves.
- R7: If an edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: `irq` is the OR over all lines of (flag AND interrupt mask). Flags still latch edges while masked.
- R9: `wake` is the OR over all lines of (flag AND wake mask).
- R10: Register bits at or above `NUM_LINES` read 0 and ignore writes. Writes to the input-level register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from registers |
| pad_in | input | NUM_LINES | Asynchronous line levels from the pads |
| pad_out | output | NUM_LINES | Level driven on each line |
| pad_oe | output | NUM_LINES | Drive enable per line |
| irq | output | 1 | Aggregated masked interrupt |
| wake | output | 1 | Aggregated wake request |

## Verification
A wrong direction or drive bit appears on `pad_oe` or `pad_out` on the first clock edge after the faulty update. A bad flag, mask or sense bit appears on `irq` or `wake` within one cycle of the flag being set. A bad flag also appears on the read port in the same cycle as it is read. A synchroniser or edge detector with the wrong depth shifts the first visible change by a cycle, which the per-cycle comparison against the behavioural model catches. A lost edge, a spurious edge, or a clear that beats a simultaneous edge leaves the flag word wrong for as long as software leaves it alone.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int WORD_BITS = 32;
    localparam int MAX_LINES = 64;

    // Slots of the line window (address bits 4:3)
    localparam logic [1:0] LW_DIR   = 2'd0;
    localparam logic [1:0] LW_LEVEL = 2'd2;
    localparam logic [1:0] LW_DRIVE = 2'd3;

    // Slots of the interrupt window (address bits 4:3)
    localparam logic [1:0] IW_MASK  = 2'd0;
    localparam logic [1:0] IW_SENSE = 2'd1;
    localparam logic [1:0] IW_FLAG  = 2'd2;
    localparam logic [1:0] IW_WAKE  = 2'd3;

    typedef struct packed {
        logic       valid;
        logic       win_irq;
        logic [1:0] slot;
        logic       hi;
    } dec_t;

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stable_d, stable_q;

    always_comb begin
        meta_d   = async_in;
        stable_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= meta_d;
            stable_q <= stable_d;
        end
    end

    assign level = stable_q;

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] sense,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        // sense 0: low-to-high, sense 1: high-to-low
        assign hit[i] = sense[i] ? (prev_q[i] & ~level[i])
                                 : (level[i] & ~prev_q[i]);
    end

endmodule

// File: rtl/gpio_word_pick.sv
module gpio_word_pick
    import gpio_edge_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [W-1:0]         vec,
    input  logic                 hi,
    output logic [WORD_BITS-1:0] word
);

    localparam int PW = MAX_LINES;

    logic [PW-1:0] wide;

    assign wide = PW'(vec);
    assign word = hi ? wide[PW-1:WORD_BITS] : wide[WORD_BITS-1:0];

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int NUM_LINES = 36,
    parameter int ADDR_W    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_BITS-1:0] bus_wdata,
    output logic [WORD_BITS-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq,
    output logic                 wake
);

    localparam int N  = NUM_LINES;
    localparam int PW = MAX_LINES;

    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] drive;
        logic [N-1:0] mask;
        logic [N-1:0] sense;
        logic [N-1:0] flag;
        logic [N-1:0] wken;
    } regs_t;

    regs_t regs_d, regs_q;
    dec_t  dec;

    logic [N-1:0]  level;
    logic [N-1:0]  edge_hit;
    logic [N-1:0]  rd_vec;
    logic [PW-1:0] lane_mask;
    logic [PW-1:0] lane_data;
    logic [N-1:0]  wmask;
    logic [N-1:0]  wdat;
    logic [N-1:0]  clr;
    logic          wr_line, wr_irq;
    logic          unused_bits;

    gpio_line_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .level    (level)
    );

    gpio_edge_unit #(.W(N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .sense (regs_q.sense),
        .hit   (edge_hit)
    );

    // Address decode
    always_comb begin
        dec.valid   = (bus_addr[ADDR_W-2:5] == '0);
        dec.win_irq = bus_addr[ADDR_W-1];
        dec.slot    = bus_addr[4:3];
        dec.hi      = bus_addr[2];
    end

    // Per-word write lanes
    assign lane_mask = dec.hi ? {{WORD_BITS{1'b1}}, {WORD_BITS{1'b0}}}
                              : {{WORD_BITS{1'b0}}, {WORD_BITS{1'b1}}};
    assign lane_data = {bus_wdata, bus_wdata};
    assign wmask     = lane_mask[N-1:0];
    assign wdat      = lane_data[N-1:0];
    assign wr_line   = bus_we && dec.valid && !dec.win_irq;
    assign wr_irq    = bus_we && dec.valid &&  dec.win_irq;

    assign unused_bits = ^{bus_addr[1:0], lane_mask, lane_data};

    function automatic logic [N-1:0] merge_lane(
        input logic [N-1:0] old_v,
        input logic [N-1:0] new_v,
        input logic [N-1:0] m
    );
        return (old_v & ~m) | (new_v & m);
    endfunction

    // Next-state computation
    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr_line) begin
            case (dec.slot)
                LW_DIR:   regs_d.dir   = merge_lane(regs_q.dir,   wdat, wmask);
                LW_DRIVE: regs_d.drive = merge_lane(regs_q.drive, wdat, wmask);
                default:  ;
            endcase
        end
        if (wr_irq) begin
            case (dec.slot)
                IW_MASK:  regs_d.mask  = merge_lane(regs_q.mask,  wdat, wmask);
                IW_SENSE: regs_d.sense = merge_lane(regs_q.sense, wdat, wmask);
                IW_FLAG:  clr          = wdat & wmask;
                IW_WAKE:  regs_d.wken  = merge_lane(regs_q.wken,  wdat, wmask);
                default:  ;
            endcase
        end
        // a new edge overrides a clear in the same cycle
        regs_d.flag = (regs_q.flag & ~clr) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read selection
    always_comb begin
        rd_vec = '0;
        if (dec.valid) begin
            if (!dec.win_irq) begin
                case (dec.slot)
                    LW_DIR:   rd_vec = regs_q.dir;
                    LW_LEVEL: rd_vec = level;
                    LW_DRIVE: rd_vec = regs_q.drive;
                    default:  rd_vec = '0;
                endcase
            end else begin
                case (dec.slot)
                    IW_MASK:  rd_vec = regs_q.mask;
                    IW_SENSE: rd_vec = regs_q.sense;
                    IW_FLAG:  rd_vec = regs_q.flag;
                    default:  rd_vec = regs_q.wken;
                endcase
            end
        end
    end

    gpio_word_pick #(.W(N)) u_pick (
        .vec  (rd_vec),
        .hi   (dec.hi),
        .word (bus_rdata)
    );

    assign pad_oe  = regs_q.dir;
    assign pad_out = regs_q.drive;
    assign irq     = |(regs_q.flag & regs_q.mask);
    assign wake    = |(regs_q.flag & regs_q.wken);

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
    parameter int NUM_LINES = 36,
    parameter int ADDR_W    = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic                 irq,
    input logic                 wake,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] wken_q,
    input logic [NUM_LINES-1:0] flag_q,
    input logic [NUM_LINES-1:0] edge_hit
);

    localparam int LO      = (NUM_LINES < 32) ? NUM_LINES : 32;
    localparam int HI_BITS = (NUM_LINES > 32) ? NUM_LINES - 32 : 0;

    logic past_ok;
    logic flag_wr;
    logic unused_chk;

    assign flag_wr = bus_we && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:5] == '0)
                     && (bus_addr[4:3] == 2'd2);
    assign unused_chk = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r3_dir_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0) |=> (pad_oe[LO-1:0] == $past(bus_wdata[LO-1:0])));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(flag_wr)) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

    a_r7_edge_lands: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    a_r9_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wken_q == '0) |-> !wake);

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[2] |-> ((64'(bus_rdata) >> HI_BITS) == 64'd0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .wake      (wake),
    .mask_q    (regs_q.mask),
    .wken_q    (regs_q.wken),
    .flag_q    (regs_q.flag),
    .edge_hit  (edge_hit)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;

    localparam int N = 36;
    localparam int AW = 7;
    localparam logic [63:0] LM = (N == 64) ? '1 : ((64'd1 << N) - 64'd1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic          b_we = 1'b0;
    logic [31:0]   b_wdata = '0;
    logic [31:0]   b_rdata;
    logic [N-1:0]  b_pin = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] m_oe = 0, m_out = 0, m_en = 0, m_pol = 0, m_st = 0, m_wk = 0;
    logic [63:0] m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [31:0] rng = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    gpio_edge_bank #(.NUM_LINES(N), .ADDR_W(AW)) u_gpio_edge_bank (
        .clk (clk), .rst_n (rst_n), .bus_addr (b_addr), .bus_we (b_we),
        .bus_wdata (b_wdata), .bus_rdata (b_rdata), .pad_in (b_pin),
        .pad_out (pad_out), .pad_oe (pad_oe), .irq (irq), .wake (wake)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [63:0] v;
        v = 64'd0;
        if (!a[5]) begin
            if (!a[6]) begin
                case (a[4:3])
                    2'd0: v = m_oe;
                    2'd2: v = m_s2;
                    2'd3: v = m_out;
                    default: v = 64'd0;
                endcase
            end else begin
                case (a[4:3])
                    2'd0: v = m_en;
                    2'd1: v = m_pol;
                    2'd2: v = m_st;
                    default: v = m_wk;
                endcase
            end
        end
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    task automatic model_tick();
        logic [63:0] hit, wm, wd, clr;
        hit = ((m_s2 & ~m_prev & ~m_pol) | (~m_s2 & m_prev & m_pol)) & LM;
        wm  = b_addr[2] ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
        wd  = {b_wdata, b_wdata} & wm & LM;
        clr = 64'd0;
        if (b_we && !b_addr[5]) begin
            if (!b_addr[6]) begin
                case (b_addr[4:3])
                    2'd0: m_oe  = (m_oe  & ~wm) | wd;
                    2'd3: m_out = (m_out & ~wm) | wd;
                    default: ;
                endcase
            end else begin
                case (b_addr[4:3])
                    2'd0: m_en  = (m_en  & ~wm) | wd;
                    2'd1: m_pol = (m_pol & ~wm) | wd;
                    2'd2: clr   = wd;
                    default: m_wk = (m_wk & ~wm) | wd;
                endcase
            end
        end
        m_st   = (m_st & ~clr) | hit;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = 64'(b_pin);
    endtask

    task automatic step();
        model_tick();
        @(posedge clk);
        @(negedge clk);
        chk("R3 pad_oe", 64'(pad_oe), m_oe);
        chk("R3 pad_out", 64'(pad_out), m_out);
        chk("R8 irq", 64'(irq), 64'(|(m_st & m_en)));
        chk("R9 wake", 64'(wake), 64'(|(m_st & m_wk)));
        chk("R2 read data", 64'(b_rdata), 64'(model_read(b_addr)));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        b_addr = a; b_we = 1'b1; b_wdata = d;
        step();
        b_we = 1'b0; b_wdata = '0;
    endtask

    task automatic peek(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        b_addr = a;
        #1;
        chk(tag, 64'(b_rdata), 64'(exp));
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [AW-1:0] pick_addr(input logic [3:0] k);
        case (k)
            4'd0: return 7'h00;  4'd1: return 7'h04;  4'd2: return 7'h10;
            4'd3: return 7'h14;  4'd4: return 7'h18;  4'd5: return 7'h1C;
            4'd6: return 7'h40;  4'd7: return 7'h44;  4'd8: return 7'h48;
            4'd9: return 7'h4C;  4'd10: return 7'h50; 4'd11: return 7'h54;
            4'd12: return 7'h58; 4'd13: return 7'h5C; 4'd14: return 7'h08;
            default: return 7'h64;
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset and right after release
        chk("R1 pad_oe in reset", 64'(pad_oe), 64'd0);
        chk("R1 irq in reset", 64'(irq), 64'd0);
        rst_n = 1'b1;
        peek(7'h00, 32'h0, "R1 direction reads 0");
        peek(7'h18, 32'h0, "R1 drive reads 0");
        peek(7'h50, 32'h0, "R1 flags read 0");
        peek(7'h4C, 32'h0, "R1 sense high reads 0");
        step();

        // R3 / R10: direction and drive, upper bits dropped
        wr(7'h00, 32'hA5A5_0F0F);
        wr(7'h04, 32'hFFFF_FFFF);
        peek(7'h04, 32'h0000_000F, "R10 upper direction bits");
        wr(7'h18, 32'h1234_5678);
        wr(7'h1C, 32'hFFFF_FFF5);
        chk("R3 pad_out value", 64'(pad_out), 64'h5_1234_5678);
        chk("R3 pad_oe value", 64'(pad_oe), 64'hF_A5A5_0F0F);
        wr(7'h10, 32'hFFFF_FFFF);
        peek(7'h10, 32'h0, "R10 input level is read-only");

        // R4 / R5: synchroniser depth and rising edge timing
        b_pin = 36'h8_0000_0001;
        b_addr = 7'h10;
        step();
        chk("R4 level after one edge", 64'(b_rdata), 64'd0);
        step();
        chk("R4 level after two edges", 64'(b_rdata), 64'd1);
        b_addr = 7'h50;
        step();
        chk("R5 rising flag set", 64'(b_rdata), 64'd1);
        peek(7'h54, 32'h8, "R5 line 35 flag");
        peek(7'h14, 32'h8, "R2 line 35 at upper word bit 3");
        chk("R8 flags latched while masked", 64'(irq), 64'd0);

        // R8 / R9
        wr(7'h40, 32'h1);
        chk("R8 irq with mask", 64'(irq), 64'd1);
        wr(7'h5C, 32'h8);
        chk("R9 wake with mask", 64'(wake), 64'd1);

        // R6: write-one-to-clear
        wr(7'h50, 32'hFFFF_FFFE);
        peek(7'h50, 32'h1, "R6 zero bits keep flag");
        wr(7'h50, 32'h1);
        peek(7'h50, 32'h0, "R6 one clears flag");
        chk("R6 irq drops after clear", 64'(irq), 64'd0);
        wr(7'h54, 32'h8);
        chk("R9 wake drops after clear", 64'(wake), 64'd0);

        // R5: falling sense on line 1
        wr(7'h48, 32'h2);
        b_pin = 36'h8_0000_0003;
        repeat (3) step();
        peek(7'h50, 32'h0, "R5 rise ignored on falling sense");
        b_pin = 36'h8_0000_0001;
        repeat (3) step();
        peek(7'h50, 32'h2, "R5 falling flag set");
        chk("R8 unmasked line only", 64'(irq), 64'd0);
        wr(7'h50, 32'h2);

        // R7: edge and clear in the same cycle
        b_pin = 36'h8_0000_0000;
        repeat (3) step();
        peek(7'h50, 32'h0, "R5 fall ignored on rising sense");
        b_pin = 36'h8_0000_0001;
        step();
        step();
        wr(7'h50, 32'h1);
        peek(7'h50, 32'h1, "R7 edge wins over clear");
        chk("R7 irq stays", 64'(irq), 64'd1);
        wr(7'h50, 32'h1);
        peek(7'h50, 32'h0, "R6 later clear works");

        // R2: unmapped addresses
        peek(7'h08, 32'h0, "R2 unmapped line slot");
        wr(7'h64, 32'hFFFF_FFFF);
        peek(7'h64, 32'h0, "R2 bit 5 set is unmapped");
        peek(7'h40, 32'h1, "R2 bit 5 write ignored");

        // Mixed traffic against the model
        for (int i = 0; i < 800; i++) begin
            rng = nxt(rng);
            b_addr = pick_addr(rng[3:0]);
            b_we = rng[4] & rng[5];
            if (rng[6]) begin
                logic [31:0] t;
                t = nxt(rng ^ 32'h5A5A_5A5A);
                b_pin = b_pin ^ N'({t[3:0], t});
            end
            rng = nxt(rng);
            b_wdata = rng;
            step();
        end
        b_we = 1'b0;

        done = 1;
        summary();
        $finish;
    end

endmodule